// File: doc/BRIEF.md
# Stereo Audio Frame Serializer

This block turns pairs of parallel audio samples into a three-wire serial audio stream: a bit clock, a word clock that marks the left or right channel, and one serial data line. It always runs as the clock master. Both clocks come from a single-cycle enable, `tick`, which the surrounding chip provides at twice the wanted bit rate. Each tick is one half period of the bit clock.

A 3-bit format code selects how each channel slot is laid out:

| Code | Slot length | Word length | Justification | Delay bit |
|------|-------------|-------------|---------------|-----------|
| 0 | 32 | 24 | left | no |
| 1 | 32 | 24 | left | yes |
| 2 | 32 | 16 | right | no |
| 3 | 32 | 24 | right | no |
| 4 | 24 | 24 | left | no |
| 5 | reserved | | | |
| 6 | 24 | 16 | right | no |
| 7 | 24 | 24 | right | no |

Two further inputs invert the bit clock and the word clock. The format code and both polarity bits are taken in only at a frame boundary, together with a new sample pair offered on a valid/ready handshake. A frame with no offered sample repeats the previous pair.

Top module: `audio_frame_serializer`

## Requirements
- R1: Reset state. The first frame uses code 1, bit-clock polarity 1 and word-clock polarity 0. Held samples are zero. `bclk_o` is 1, and `wclk_o`, `sdata_o`, `mode_err_o` are 0.
- R2: Each `tick` toggles an internal bit-clock phase. `bclk_o` equals that phase when the bit-clock polarity is 1, and its inverse when it is 0. The phase starts at 1, and a 1-to-0 phase change is the shift edge.
- R3: `sdata_o` and `wclk_o` change only in the clock cycle after a shift edge. They are stable across idle cycles and across the other half period.
- R4: A frame lasts 64 shift edges for codes 0 to 3, and 48 for codes 4 to 7. The first half of the frame is the left slot and the second half is the right slot.
- R5: `wclk_o` equals the channel (0 = left, 1 = right) XOR the word-clock polarity bit. With polarity 0, low marks the left channel.
- R6: Only code 1 inserts a delay bit: slot bit 0 is zero and the word MSB is in slot bit 1. Every other code starts data without a delay bit.
- R7: In left-justified codes (0, 1, 4), the word is sent MSB first from the first data bit, and the remaining slot bits are zero.
- R8: In right-justified codes (2, 3, 6, 7), the word LSB is in the last slot bit and the leading bits are zero. A 16-bit word is taken from sample bits [23:8], and a 24-bit word from bits [23:0].
- R9: While a frame runs with code 5, `sdata_o` stays 0 and `mode_err_o` is 1. That frame lasts 48 shift edges.
- R10: `smp_ready_o` is high only in the cycle of the shift edge that ends a frame. If `smp_valid_i` is high in that cycle, the offered pair is sent in the next frame; otherwise the previous pair is repeated.
- R11: The format code and both polarity inputs are sampled only at the frame-ending shift edge. A change in the middle of a frame does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-bit-period enable |
| mode_i | input | 3 | Frame format code |
| bclk_pol_i | input | 1 | Bit-clock polarity bit |
| wclk_pol_i | input | 1 | Word-clock polarity bit |
| smp_valid_i | input | 1 | A sample pair is offered |
| smp_ready_o | output | 1 | The offered pair is taken in this cycle |
| left_i | input | SAMPLE_W | Left sample, MSB-aligned |
| right_i | input | SAMPLE_W | Right sample, MSB-aligned |
| bclk_o | output | 1 | Serial bit clock |
| wclk_o | output | 1 | Word (channel) clock |
| sdata_o | output | 1 | Serial data |
| mode_err_o | output | 1 | The current frame uses the reserved code |

## Verification
The assertions assume that `tick` is a single-cycle enable and that the polarity inputs change the bit clock only at a frame boundary, where the phase toggle and any polarity change can coincide. The bench keeps `tick` high for exactly one clock and adds random idle gaps between ticks. It changes the format code, the polarities and the sample data only between ticks, and it keeps `smp_valid_i` and the offered data steady until the pair is taken. Each run starts from a clean reset, so the counter and held state begin at known values.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int MAX_SLOT = 32;
  localparam int POS_W    = $clog2(2 * MAX_SLOT);

  typedef struct packed {
    logic [2:0] mode;
    logic       bpol;
    logic       wpol;
  } aser_cfg_t;

  localparam aser_cfg_t CFG_RESET = '{mode: 3'd1, bpol: 1'b1, wpol: 1'b0};

  function automatic logic [POS_W-1:0] slot_bits(input logic [2:0] mode);
    return mode[2] ? POS_W'(24) : POS_W'(32);
  endfunction

  function automatic logic [POS_W-1:0] word_bits(input logic [2:0] mode);
    return (mode == 3'd2 || mode == 3'd6) ? POS_W'(16) : POS_W'(24);
  endfunction

  function automatic logic right_just(input logic [2:0] mode);
    return mode[1];
  endfunction

  function automatic logic [POS_W-1:0] lead_bits(input logic [2:0] mode);
    if (right_just(mode)) return slot_bits(mode) - word_bits(mode);
    return (mode == 3'd1) ? POS_W'(1) : POS_W'(0);
  endfunction

  function automatic logic is_reserved(input logic [2:0] mode);
    return mode == 3'd5;
  endfunction
endpackage

// File: rtl/aser_bclk_gen.sv
module aser_bclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase_o,
  output logic fall_evt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_o <= 1'b1;
    else if (tick) phase_o <= ~phase_o;
  end

  assign fall_evt_o = tick & phase_o;
endmodule

// File: rtl/aser_frame_ctr.sv
module aser_frame_ctr #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [POS_W-1:0] last_pos_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic             wrap_o
);
  assign wrap_o    = step_i && (pos_o == last_pos_i);
  assign pos_nxt_o = wrap_o ? '0 : (step_i ? pos_o + POS_W'(1) : pos_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_o <= '0;
    else        pos_o <= pos_nxt_o;
  end
endmodule

// File: rtl/aser_bit_select.sv
module aser_bit_select
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [2:0]          mode_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                chan_o,
  output logic                bit_o
);
  logic [POS_W-1:0]    slot, lead, wlen, k, off;
  logic [SAMPLE_W-1:0] word, shifted;
  logic                in_word;

  always_comb begin
    slot    = slot_bits(mode_i);
    lead    = lead_bits(mode_i);
    wlen    = word_bits(mode_i);
    chan_o  = (pos_i >= slot);
    k       = chan_o ? pos_i - slot : pos_i;
    word    = chan_o ? right_i : left_i;
    off     = k - lead;
    in_word = (k >= lead) && (off < wlen);
    shifted = word << off;
    bit_o   = in_word && !is_reserved(mode_i) && shifted[SAMPLE_W-1];
  end
endmodule

// File: rtl/audio_frame_serializer.sv
module audio_frame_serializer
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [2:0]          mode_i,
  input  logic                bclk_pol_i,
  input  logic                wclk_pol_i,
  input  logic                smp_valid_i,
  output logic                smp_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                sdata_o,
  output logic                mode_err_o
);
  aser_cfg_t           cfg_q, cfg_nxt;
  logic [SAMPLE_W-1:0] left_q, right_q, left_nxt, right_nxt;
  logic                phase, fall_evt, frame_wrap, accept;
  logic [POS_W-1:0]    pos_q, pos_nxt, last_pos;
  logic                nxt_chan, nxt_bit;

  aser_bclk_gen u_bclk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .phase_o(phase), .fall_evt_o(fall_evt)
  );

  assign last_pos = POS_W'({1'b0, slot_bits(cfg_q.mode)} * 2 - 1);

  aser_frame_ctr #(.POS_W(POS_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step_i(fall_evt), .last_pos_i(last_pos),
    .pos_o(pos_q), .pos_nxt_o(pos_nxt), .wrap_o(frame_wrap)
  );

  assign accept      = frame_wrap & smp_valid_i;
  assign smp_ready_o = frame_wrap;
  assign cfg_nxt     = frame_wrap ? '{mode: mode_i, bpol: bclk_pol_i, wpol: wclk_pol_i} : cfg_q;
  assign left_nxt    = accept ? left_i  : left_q;
  assign right_nxt   = accept ? right_i : right_q;

  aser_bit_select #(.SAMPLE_W(SAMPLE_W)) u_sel (
    .mode_i(cfg_nxt.mode), .pos_i(pos_nxt), .left_i(left_nxt), .right_i(right_nxt),
    .chan_o(nxt_chan), .bit_o(nxt_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      left_q  <= '0;
      right_q <= '0;
      sdata_o <= 1'b0;
      wclk_o  <= 1'b0;
    end else if (fall_evt) begin
      cfg_q   <= cfg_nxt;
      left_q  <= left_nxt;
      right_q <= right_nxt;
      sdata_o <= nxt_bit;
      wclk_o  <= nxt_chan ^ cfg_nxt.wpol;
    end
  end

  assign bclk_o     = cfg_q.bpol ? phase : ~phase;
  assign mode_err_o = is_reserved(cfg_q.mode);
endmodule

// File: rtl/aser_checker.sv
module aser_checker
  import aser_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             smp_ready_o,
  input logic             bclk_o,
  input logic             wclk_o,
  input logic             sdata_o,
  input logic             mode_err_o,
  input logic             fall_evt,
  input logic             frame_wrap,
  input logic [POS_W-1:0] pos_q
);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> !sdata_o);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdata_o) && $stable(wclk_o));

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready_o |=> pos_q == '0);

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !frame_wrap |=> bclk_o != $past(bclk_o));

  assert_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(pos_q));

  assert_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> pos_q < POS_W'(48));
endmodule

bind audio_frame_serializer aser_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .smp_ready_o(smp_ready_o),
  .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o), .mode_err_o(mode_err_o),
  .fall_evt(fall_evt), .frame_wrap(frame_wrap), .pos_q(pos_q)
);

// File: tb/audio_frame_serializer_tb.sv
`timescale 1ns/1ps
module audio_frame_serializer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic bclk_pol_i = 1'b1, wclk_pol_i = 1'b0, smp_valid_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic smp_ready_o, bclk_o, wclk_o, sdata_o, mode_err_o;

  audio_frame_serializer u_dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // bench reference state
  bit m_phase = 1, m_bp = 1, m_wp = 0;
  int m_pos = 0, m_mode = 1, m_wraps = 0;
  logic [23:0] m_l = '0, m_r = '0;
  bit m_acc = 0;

  function automatic int slot_of(int md); return (md >= 4) ? 24 : 32; endfunction

  function automatic bit exp_bit(int md, int pos, logic [23:0] l, logic [23:0] r);
    int s = slot_of(md);
    int w = (md == 2 || md == 6) ? 16 : 24;
    bit rj = (md == 2 || md == 3 || md == 6 || md == 7);
    int k = pos % s;
    int first = rj ? s - w : (md == 1 ? 1 : 0);
    logic [23:0] wd = (pos >= s) ? r : l;
    if (md == 5) return 1'b0;
    if (k < first || k >= first + w) return 1'b0;
    return wd[23 - (k - first)];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_out(bit idle);
    bit eb = m_bp ? m_phase : !m_phase;
    bit ew = (m_pos >= slot_of(m_mode)) ^ m_wp;
    bit ed = exp_bit(m_mode, m_pos, m_l, m_r);
    string dt = (m_mode == 5) ? "R9" : (m_mode == 1) ? "R6" :
                (m_mode == 2 || m_mode == 3 || m_mode >= 6) ? "R8" : "R7";
    check(bclk_o == eb, "R2 bclk", bclk_o, eb);
    check(wclk_o == ew, idle ? "R3 wclk" : "R5 wclk", wclk_o, ew);
    check(sdata_o == ed, idle ? "R3 sdata" : dt, sdata_o, ed);
    check(mode_err_o == (m_mode == 5), "R9 err", mode_err_o, m_mode == 5);
  endtask

  // one tick, then a random number of idle cycles
  task automatic step(int gap);
    bit wrap;
    tick = 1'b1;
    #1;
    wrap = m_phase && (m_pos == 2 * slot_of(m_mode) - 1);
    check(smp_ready_o == wrap, wrap ? "R4 frame end" : "R10 ready", smp_ready_o, wrap);
    @(posedge clk);
    m_acc = 0;
    if (m_phase) begin
      if (wrap) begin
        m_pos = 0; m_wraps++;
        m_mode = mode_i; m_bp = bclk_pol_i; m_wp = wclk_pol_i;
        if (smp_valid_i) begin m_l = left_i; m_r = right_i; m_acc = 1; end
      end else m_pos++;
    end
    m_phase = !m_phase;
    @(negedge clk);
    tick = 1'b0;
    cmp_out(0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      cmp_out(1);
    end
  endtask

  task automatic new_offer();
    smp_valid_i = ($urandom % 3) != 0;
    left_i = $urandom; right_i = $urandom;
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bclk_o == 1'b1, "R1 bclk", bclk_o, 1);
    check(wclk_o == 1'b0, "R1 wclk", wclk_o, 0);
    check(sdata_o == 1'b0, "R1 sdata", sdata_o, 0);
    check(mode_err_o == 1'b0, "R1 err", mode_err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_ready_o == 1'b0, "R1 ready", smp_ready_o, 0);
    // R11: a mid-frame change to the reserved code waits for the frame end
    mode_i = 3'd5; wclk_pol_i = 1'b1;
    for (int i = 0; i < 10; i++) step(0);
    check(mode_err_o == 1'b0, "R11 err held", mode_err_o, 0);
    check(wclk_o == 1'b0, "R11 wclk held", wclk_o, 0);
    while (m_wraps < 1) step($urandom % 2);
    check(mode_err_o == 1'b1, "R9 err at frame", mode_err_o, 1);
    mode_i = 3'd1; wclk_pol_i = 1'b0;
    smp_valid_i = 1'b1; left_i = 24'h800001; right_i = 24'hFFFFFF;
    while (m_wraps < 3) begin
      step(0);
      if (m_acc) smp_valid_i = 1'b0;
    end
    // R10: no offer, so the pair is repeated
    check(m_l == 24'h800001, "R10 repeat", m_l, 24'h800001);
    for (int s = 0; s < 24; s++) begin
      int target;
      mode_i = (s < 8) ? 3'(s) : 3'($urandom % 8);
      bclk_pol_i = (s < 8) ? s[0] : 1'($urandom);
      wclk_pol_i = (s < 8) ? s[1] : 1'($urandom);
      new_offer();
      target = m_wraps + 2;
      while (m_wraps < target) begin
        step($urandom % 3);
        if (m_acc) new_offer();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule